// File: doc/BRIEF.md
# Multi-Core Accelerator Control Register File

This block is the host-facing control register file for a cluster of one to three compute cores. A host reaches it through a 32-bit AXI4-Lite slave port clocked by the slave clock. For every core it keeps a reset bit, a start control, an instruction start address and a set of 40-bit data base addresses. It drives these values straight onto per-core output buses, where the cores pick up their configuration.

Each core returns one single-cycle completion pulse per task. A pulse sets that core's bit in a shared completion status word and raises the core's own active-high interrupt line. The bit and the line stay set until the host writes to that core's start register. Writing 0 to the start register parks the core. Writing 1 clears the old completion and starts the next task.

Every core owns a 256-byte register page, and the pages follow one another at a fixed stride. Each 40-bit address is split into a low word and a high word. The offsets below are the interface contract with the host driver, so they are fixed.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero, and the core reset, start, instruction address, base address and interrupt outputs are all zero.
- R2: The word at 0x004 holds one active-high core reset per core, with bit n driving core_rst[n]. It is read/write. Bits at or above NUM_CORES read zero and ignore writes.
- R3: The start word of core c sits at 0x220 + 0x100*c. Bit 0 drives core_start[c] and reads back, and the other bits read zero.
- R4: The instruction start address of core c is a 32-bit read/write word at 0x20C + 0x100*c. It drives core_instr_addr[32*c +: 32].
- R5: Base address k (0..7) of core c keeps its low 32 bits at 0x224 + 0x100*c + 8*k and its upper 8 bits in bits [7:0] of the next word. The other bits of that next word read zero. The output core_base_addr[40*(8*c+k) +: 40] equals {upper, low}.
- R6: A one-cycle pulse on core_done[c] sets bit c of the read-only status word at 0x608, and sets core_irq[c], from the next cycle on. The bits of the other cores are unchanged. The bit stays set until it is cleared as in R7.
- R7: A write to the start word of core c with byte lane 0 enabled clears that core's status bit and interrupt. When a completion pulse for the same core arrives in the same cycle, the status bit ends up set.
- R8: Writes to the status word at 0x608 have no effect on any status bit or interrupt.
- R9: Reads of an unmapped word, including the pages of cores at or above NUM_CORES, return zero. Writes to an unmapped word change no register and no output.
- R10: Writes honour the byte-lane strobes: a byte whose strobe bit is 0 keeps its old value. For the start word and the high address words, only lane 0 carries data.
- R11: The write address and the write data are accepted together in one cycle, and the response follows in the next cycle. A read's response follows its address handshake by one cycle. Every response is OKAY (00). Only one access of each kind is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Slave clock |
| aresetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_awaddr | input | 12 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_rst | output | NUM_CORES | Active-high reset for each core |
| core_start | output | NUM_CORES | Start level for each core |
| core_instr_addr | output | 32*NUM_CORES | Instruction start address for each core |
| core_base_addr | output | 40*8*NUM_CORES | Eight 40-bit base addresses for each core |
| core_done | input | NUM_CORES | One-cycle completion pulse from each core |
| core_irq | output | NUM_CORES | Active-high interrupt for each core |

## Verification
Every register value is also driven live onto a core-side output. A wrong decode, a wrong byte merge or a lost write therefore shows up on the matching output bus in the cycle after the write handshake, before any read-back. A completion bit that is set wrongly, or lost, shows up the same way on core_irq one cycle after the done pulse or the start write. The bench compares all outputs with its own model after every transaction. It also reads words back, so that decode aliasing between pages is exposed.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned ACR_AW = 12;
  localparam int unsigned ACR_DW = 32;
  localparam int unsigned ACR_SW = ACR_DW / 8;

  localparam logic [ACR_AW-1:0] REG_CORE_RST  = 12'h004;
  localparam logic [ACR_AW-1:0] REG_DONE_STAT = 12'h608;
  localparam logic [3:0]        FIRST_PAGE    = 4'h2;
  localparam logic [7:0]        OFF_INSTR     = 8'h0C;
  localparam logic [7:0]        OFF_START     = 8'h20;
  localparam logic [7:0]        OFF_BASE      = 8'h24;

  typedef struct packed {
    logic              fire;
    logic [ACR_AW-1:0] addr;
    logic [ACR_DW-1:0] data;
    logic [ACR_SW-1:0] strb;
  } acr_wr_t;

  function automatic logic [ACR_DW-1:0] lane_merge(input logic [ACR_DW-1:0] cur,
                                                   input logic [ACR_DW-1:0] nxt,
                                                   input logic [ACR_SW-1:0] strb);
    logic [ACR_DW-1:0] res;
    for (int b = 0; b < int'(ACR_SW); b++) begin
      res[b*8 +: 8] = strb[b] ? nxt[b*8 +: 8] : cur[b*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [ACR_AW-1:0] word_of(input logic [ACR_AW-1:0] a);
    return {a[ACR_AW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/acr_rst_sync.sv
module acr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/acr_axil_port.sv
module acr_axil_port
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACR_AW-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ACR_DW-1:0] wdata,
  input  logic [ACR_SW-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ACR_AW-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [ACR_DW-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output acr_wr_t           wr,
  output logic [ACR_AW-1:0] rd_addr,
  input  logic [ACR_DW-1:0] rd_data
);
  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [ACR_DW-1:0] rdata_q, rdata_d;
  logic              wr_fire, rd_fire;

  // address and data are taken together, one response at a time
  assign wr_fire = awvalid && wvalid && !bvalid_q;
  assign awready = wr_fire;
  assign wready  = wr_fire;
  assign arready = !rvalid_q;
  assign rd_fire = arvalid && !rvalid_q;

  assign wr.fire = wr_fire;
  assign wr.addr = awaddr;
  assign wr.data = wdata;
  assign wr.strb = wstrb;
  assign rd_addr = araddr;

  always_comb begin
    bvalid_d = bvalid_q;
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (wr_fire)     bvalid_d = 1'b1;
    else if (bready) bvalid_d = 1'b0;
    if (rd_fire) begin
      rvalid_d = 1'b1;
      rdata_d  = rd_data;
    end else if (rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bvalid = bvalid_q;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign bresp  = 2'b00;
  assign rresp  = 2'b00;

  AST_WR_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready |=> bvalid); // R11
  AST_RD_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && arready |=> rvalid); // R11
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && !awready); // R11
endmodule

// File: rtl/acr_core_bank.sv
module acr_core_bank
  import acr_pkg::*;
#(
  parameter int unsigned CORE_ID = 0,
  parameter int unsigned BASE_N  = 8,
  parameter int unsigned HI_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  acr_wr_t                       wr,
  input  logic [ACR_AW-1:0]             rd_addr,
  output logic [ACR_DW-1:0]             rd_data,
  input  logic                          done,
  output logic                          start,
  output logic [ACR_DW-1:0]             instr_addr,
  output logic [BASE_N*(ACR_DW+HI_W)-1:0] base_addr,
  output logic                          stat
);
  localparam int unsigned BASE_W  = ACR_DW + HI_W;
  localparam logic [3:0]  PAGE    = FIRST_PAGE + 4'(CORE_ID);
  localparam logic [7:0]  BASE_HI = OFF_BASE + 8'(8 * BASE_N);

  logic              start_q, start_d;
  logic              stat_q, stat_d;
  logic [ACR_DW-1:0] instr_q, instr_d;
  logic [ACR_DW-1:0] lo_q [BASE_N];
  logic [ACR_DW-1:0] lo_d [BASE_N];
  logic [HI_W-1:0]   hi_q [BASE_N];
  logic [HI_W-1:0]   hi_d [BASE_N];

  logic       wr_pg, wr_base, start_wr;
  logic [7:0] wr_off, wr_rel;
  logic       rd_pg, rd_base;
  logic [7:0] rd_off, rd_rel;

  assign wr_pg    = wr.fire && (wr.addr[11:8] == PAGE);
  assign wr_off   = {wr.addr[7:2], 2'b00};
  assign wr_rel   = wr_off - OFF_BASE;
  assign wr_base  = wr_pg && (wr_off >= OFF_BASE) && (wr_off < BASE_HI);
  assign start_wr = wr_pg && (wr_off == OFF_START) && wr.strb[0];

  always_comb begin
    start_d = start_q;
    stat_d  = stat_q;
    instr_d = instr_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (wr_pg && (wr_off == OFF_INSTR)) instr_d = lane_merge(instr_q, wr.data, wr.strb);
    if (start_wr) begin
      start_d = wr.data[0];
      stat_d  = 1'b0;
    end
    for (int k = 0; k < int'(BASE_N); k++) begin
      if (wr_base && (wr_rel[7:3] == 5'(k))) begin
        if (wr_rel[2]) begin
          if (wr.strb[0]) hi_d[k] = wr.data[HI_W-1:0];
        end else begin
          lo_d[k] = lane_merge(lo_q[k], wr.data, wr.strb);
        end
      end
    end
    if (done) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stat_q  <= 1'b0;
      instr_q <= '0;
      for (int k = 0; k < int'(BASE_N); k++) begin
        lo_q[k] <= '0;
        hi_q[k] <= '0;
      end
    end else begin
      start_q <= start_d;
      stat_q  <= stat_d;
      instr_q <= instr_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign rd_pg   = rd_addr[11:8] == PAGE;
  assign rd_off  = {rd_addr[7:2], 2'b00};
  assign rd_rel  = rd_off - OFF_BASE;
  assign rd_base = rd_pg && (rd_off >= OFF_BASE) && (rd_off < BASE_HI);

  always_comb begin
    rd_data = '0;
    if (rd_pg && (rd_off == OFF_INSTR)) rd_data = instr_q;
    if (rd_pg && (rd_off == OFF_START)) rd_data = ACR_DW'(start_q);
    for (int k = 0; k < int'(BASE_N); k++) begin
      if (rd_base && (rd_rel[7:3] == 5'(k))) begin
        rd_data = rd_rel[2] ? ACR_DW'(hi_q[k]) : lo_q[k];
      end
    end
  end

  for (genvar k = 0; k < int'(BASE_N); k++) begin : g_base
    assign base_addr[k*BASE_W +: BASE_W] = {hi_q[k], lo_q[k]};
  end

  assign start      = start_q;
  assign stat       = stat_q;
  assign instr_addr = instr_q;

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat && !start_wr |=> stat); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !done |=> !stat); // R7
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> start == $past(wr.data[0])); // R3
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import acr_pkg::*;
#(
  parameter int unsigned NUM_CORES = 3,
  parameter int unsigned BASE_N    = 8,
  parameter int unsigned HI_W      = 8
) (
  input  logic                                    aclk,
  input  logic                                    aresetn,
  input  logic [11:0]                             s_awaddr,
  input  logic                                    s_awvalid,
  output logic                                    s_awready,
  input  logic [31:0]                             s_wdata,
  input  logic [3:0]                              s_wstrb,
  input  logic                                    s_wvalid,
  output logic                                    s_wready,
  output logic [1:0]                              s_bresp,
  output logic                                    s_bvalid,
  input  logic                                    s_bready,
  input  logic [11:0]                             s_araddr,
  input  logic                                    s_arvalid,
  output logic                                    s_arready,
  output logic [31:0]                             s_rdata,
  output logic [1:0]                              s_rresp,
  output logic                                    s_rvalid,
  input  logic                                    s_rready,
  output logic [NUM_CORES-1:0]                    core_rst,
  output logic [NUM_CORES-1:0]                    core_start,
  output logic [NUM_CORES*32-1:0]                 core_instr_addr,
  output logic [NUM_CORES*BASE_N*(32+HI_W)-1:0]   core_base_addr,
  input  logic [NUM_CORES-1:0]                    core_done,
  output logic [NUM_CORES-1:0]                    core_irq
);
  localparam int unsigned BASE_W    = ACR_DW + HI_W;
  localparam int unsigned BANK_BITS = BASE_N * BASE_W;

  logic              rst_n;
  acr_wr_t           wr;
  logic [ACR_AW-1:0] rd_addr;
  logic [ACR_DW-1:0] rd_data;
  logic [ACR_DW-1:0] bank_rd [NUM_CORES];
  logic [NUM_CORES-1:0] stat_vec;
  logic [NUM_CORES-1:0] rst_q, rst_d;
  logic [ACR_DW-1:0]    rst_merged;
  logic                 rst_wr;

  acr_rst_sync u_rst (.clk(aclk), .arst_n(aresetn), .srst_n(rst_n));

  acr_axil_port u_port (
    .clk(aclk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .wr(wr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  for (genvar c = 0; c < int'(NUM_CORES); c++) begin : g_core
    acr_core_bank #(.CORE_ID(c), .BASE_N(BASE_N), .HI_W(HI_W)) u_bank (
      .clk(aclk), .rst_n(rst_n), .wr(wr),
      .rd_addr(rd_addr), .rd_data(bank_rd[c]),
      .done(core_done[c]), .start(core_start[c]),
      .instr_addr(core_instr_addr[c*32 +: 32]),
      .base_addr(core_base_addr[c*BANK_BITS +: BANK_BITS]),
      .stat(stat_vec[c])
    );

    AST_IRQ_CAUSE: assert property (@(posedge aclk) disable iff (!rst_n)
      !core_irq[c] ##1 core_irq[c] |-> $past(core_done[c])); // R6
  end

  // per-core reset word; bits above the core count are never stored
  assign rst_wr     = wr.fire && (word_of(wr.addr) == REG_CORE_RST);
  assign rst_merged = lane_merge(ACR_DW'(rst_q), wr.data, wr.strb);

  always_comb begin
    rst_d = rst_q;
    if (rst_wr) rst_d = rst_merged[NUM_CORES-1:0];
  end

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_d;
  end

  always_comb begin
    rd_data = '0;
    if (word_of(rd_addr) == REG_CORE_RST)  rd_data = ACR_DW'(rst_q);
    if (word_of(rd_addr) == REG_DONE_STAT) rd_data = ACR_DW'(stat_vec);
    for (int c = 0; c < int'(NUM_CORES); c++) rd_data = rd_data | bank_rd[c];
  end

  assign core_rst = rst_q;
  assign core_irq = stat_vec;

  AST_RST_KEEP: assert property (@(posedge aclk) disable iff (!rst_n)
    !rst_wr |=> $stable(core_rst)); // R2
  AST_STAT_NO_SET: assert property (@(posedge aclk) disable iff (!rst_n)
    core_done == '0 |=> (core_irq & ~$past(core_irq)) == '0); // R8
endmodule

// File: tb/tb_accel_ctrl_regs.sv
`timescale 1ns/1ps
module tb_accel_ctrl_regs;
  localparam int NC = 3;
  localparam int NB = 8;

  logic        aclk = 1'b0;
  logic        aresetn;
  logic [11:0] s_awaddr, s_araddr;
  logic        s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [31:0] s_wdata;
  logic [3:0]  s_wstrb;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [NC-1:0] core_rst, core_start, core_done, core_irq;
  logic [NC*32-1:0]    core_instr_addr;
  logic [NC*NB*40-1:0] core_base_addr;

  always #2 aclk = ~aclk;

  accel_ctrl_regs #(.NUM_CORES(NC), .BASE_N(NB), .HI_W(8)) dut (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [NC-1:0] rst_m, start_m, stat_m;
  logic [31:0]   instr_m [NC];
  logic [31:0]   lo_m [NC][NB];
  logic [7:0]    hi_m [NC][NB];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] cur, input logic [31:0] nw, input logic [3:0] s);
    logic [31:0] r;
    r = cur;
    if (s[0]) r[7:0]   = nw[7:0];
    if (s[1]) r[15:8]  = nw[15:8];
    if (s[2]) r[23:16] = nw[23:16];
    if (s[3]) r[31:24] = nw[31:24];
    return r;
  endfunction

  task automatic model_reset();
    rst_m = '0; start_m = '0; stat_m = '0;
    for (int c = 0; c < NC; c++) begin
      instr_m[c] = '0;
      for (int k = 0; k < NB; k++) begin lo_m[c][k] = '0; hi_m[c][k] = '0; end
    end
  endtask

  // host-visible register map computed from the requirements
  task automatic model_write(input logic [11:0] ad, input logic [31:0] d, input logic [3:0] s, input logic [NC-1:0] dm);
    logic [11:0] a; logic [NC-1:0] clr; int c; logic [7:0] off, rel; logic [31:0] t;
    a = {ad[11:2], 2'b00}; clr = '0;
    if (a == 12'h004) begin
      t = bmerge(32'(rst_m), d, s); rst_m = t[NC-1:0];
    end else if (a[11:8] >= 4'h2 && a[11:8] <= 4'h4 && int'(a[11:8]) - 2 < NC) begin
      c = int'(a[11:8]) - 2; off = a[7:0];
      if (off == 8'h0C) instr_m[c] = bmerge(instr_m[c], d, s);
      else if (off == 8'h20) begin
        if (s[0]) begin start_m[c] = d[0]; clr[c] = 1'b1; end
      end else if (off >= 8'h24 && off <= 8'h60) begin
        rel = off - 8'h24;
        if (rel[2]) begin if (s[0]) hi_m[c][rel[7:3]] = d[7:0]; end
        else lo_m[c][rel[7:3]] = bmerge(lo_m[c][rel[7:3]], d, s);
      end
    end
    stat_m = (stat_m & ~clr) | dm;
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] ad);
    logic [11:0] a; int c; logic [7:0] off, rel;
    a = {ad[11:2], 2'b00};
    if (a == 12'h004) return 32'(rst_m);
    if (a == 12'h608) return 32'(stat_m);
    if (a[11:8] >= 4'h2 && a[11:8] <= 4'h4 && int'(a[11:8]) - 2 < NC) begin
      c = int'(a[11:8]) - 2; off = a[7:0];
      if (off == 8'h0C) return instr_m[c];
      if (off == 8'h20) return 32'(start_m[c]);
      if (off >= 8'h24 && off <= 8'h60) begin
        rel = off - 8'h24;
        return rel[2] ? 32'(hi_m[c][rel[7:3]]) : lo_m[c][rel[7:3]];
      end
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [11:0] ad);
    logic [11:0] a; logic [7:0] off;
    a = {ad[11:2], 2'b00}; off = a[7:0];
    if (a == 12'h004) return "R2 reset word";
    if (a == 12'h608) return "R6 status word";
    if (a[11:8] >= 4'h2 && a[11:8] <= 4'h4 && int'(a[11:8]) - 2 < NC) begin
      if (off == 8'h0C) return "R4 instr word";
      if (off == 8'h20) return "R3 start word";
      if (off >= 8'h24 && off <= 8'h60) return "R5 base word";
    end
    return "R9 unmapped word";
  endfunction

  task automatic check_outs();
    logic [NC*32-1:0] ei; logic [NC*NB*40-1:0] eb;
    for (int c = 0; c < NC; c++) begin
      ei[c*32 +: 32] = instr_m[c];
      for (int k = 0; k < NB; k++) eb[(c*NB+k)*40 +: 40] = {hi_m[c][k], lo_m[c][k]};
    end
    chk(core_rst == rst_m, "R2 core_rst", 64'(core_rst), 64'(rst_m));
    chk(core_start == start_m, "R3 core_start", 64'(core_start), 64'(start_m));
    chk(core_instr_addr == ei, "R4 core_instr_addr", core_instr_addr[63:0], ei[63:0]);
    chk(core_base_addr == eb, "R5 core_base_addr", core_base_addr[63:0], eb[63:0]);
    chk(core_irq == stat_m, "R6 core_irq", 64'(core_irq), 64'(stat_m));
  endtask

  task automatic axw(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, input logic [NC-1:0] dm);
    @(negedge aclk);
    s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1'b1; s_wvalid = 1'b1; core_done = dm;
    #1;
    chk(s_awready && s_wready, "R11 write accept", 64'({s_awready, s_wready}), 64'h3);
    @(negedge aclk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; core_done = '0;
    chk(s_bvalid == 1'b1, "R11 bvalid timing", 64'(s_bvalid), 64'h1);
    chk(s_bresp == 2'b00, "R11 bresp", 64'(s_bresp), 64'h0);
    model_write(a, d, s, dm);
  endtask

  task automatic axr(input logic [11:0] a, output logic [31:0] d);
    @(negedge aclk);
    s_araddr = a; s_arvalid = 1'b1;
    #1;
    chk(s_arready, "R11 read accept", 64'(s_arready), 64'h1);
    @(negedge aclk);
    s_arvalid = 1'b0;
    chk(s_rvalid == 1'b1, "R11 rvalid timing", 64'(s_rvalid), 64'h1);
    chk(s_rresp == 2'b00, "R11 rresp", 64'(s_rresp), 64'h0);
    d = s_rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag);
    logic [31:0] d, e;
    e = exp_read(a);
    axr(a, d);
    chk(d == e, tag, 64'(d), 64'(e));
  endtask

  task automatic pulse(input logic [NC-1:0] dm);
    @(negedge aclk); core_done = dm;
    @(negedge aclk); core_done = '0;
    stat_m = stat_m | dm;
  endtask

  function automatic logic [11:0] rand_addr();
    int c;
    c = int'($urandom % 4);
    case ($urandom % 8)
      0: return 12'h004;
      1: return 12'h608;
      2: return 12'(12'h20C + 12'h100 * c);
      3, 7: return 12'(12'h220 + 12'h100 * c);
      4, 5: return 12'(12'h224 + 12'h100 * c + 4 * ($urandom % 16));
      default: return 12'($urandom) & 12'hFFC;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge aclk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    aresetn = 1'b0; s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
    s_bready = 1'b1; s_rready = 1'b1; core_done = '0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_wstrb = '0;
    model_reset();
    repeat (4) @(negedge aclk);
    aresetn = 1'b1;
    repeat (4) @(negedge aclk);

    // R1 reset state
    chk(core_rst == 0 && core_start == 0 && core_irq == 0, "R1 control outputs", 64'({core_rst, core_start, core_irq}), 64'h0);
    chk(core_instr_addr == 0 && core_base_addr == 0, "R1 address outputs", core_base_addr[63:0], 64'h0);
    rd_chk(12'h004, "R1 reset word"); rd_chk(12'h608, "R1 status word");
    rd_chk(12'h32C, "R1 base word"); rd_chk(12'h40C, "R1 instr word");

    // R2 unused bits, R10 strobes
    axw(12'h004, 32'hFFFF_FFFF, 4'hF, '0); rd_chk(12'h004, "R2 upper bits zero"); check_outs();
    axw(12'h20C, 32'h1122_3344, 4'hF, '0);
    axw(12'h20C, 32'hAABB_CCDD, 4'b0101, '0); rd_chk(12'h20C, "R10 partial strobe");
    axw(12'h228, 32'hFFFF_FFA5, 4'hE, '0); rd_chk(12'h228, "R10 hi word lane0 off");
    axw(12'h460, 32'hFFFF_FF5A, 4'hF, '0); rd_chk(12'h460, "R5 hi word upper zero"); check_outs();

    // R6 core 1 done while core 0 busy
    axw(12'h220, 32'h1, 4'hF, '0); axw(12'h320, 32'h1, 4'hF, '0);
    pulse(3'b010); check_outs(); rd_chk(12'h608, "R6 status after core1 done");
    chk(core_irq == 3'b010, "R6 irq value 2", 64'(core_irq), 64'h2);
    pulse(3'b100); rd_chk(12'h608, "R6 second core");
    // R8 status write ignored
    axw(12'h608, 32'h0, 4'hF, '0); check_outs(); rd_chk(12'h608, "R8 status write ignored");
    // R7 clear by writing 0, restart by writing 1
    axw(12'h320, 32'h0, 4'hF, '0); check_outs(); rd_chk(12'h608, "R7 clear on start 0");
    axw(12'h420, 32'h1, 4'hF, '0); check_outs();
    chk(core_irq == 3'b000 && core_start[2], "R7 restart clears", 64'({core_irq, core_start}), 64'({3'b000, 3'b101}));
    // R7 done in same cycle as start write
    axw(12'h220, 32'h1, 4'hF, 3'b001); check_outs();
    chk(core_irq[0] == 1'b1, "R7 done wins", 64'(core_irq), 64'h1);
    // R9 unmapped
    axw(12'h210, 32'hDEAD_BEEF, 4'hF, '0); axw(12'h724, 32'hDEAD_BEEF, 4'hF, '0);
    axw(12'h524, 32'hDEAD_BEEF, 4'hF, '0); axw(12'h064, 32'hDEAD_BEEF, 4'hF, '0); check_outs();
    rd_chk(12'h210, "R9 read zero"); rd_chk(12'h524, "R9 missing core page"); rd_chk(12'h264, "R9 past last base");

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      int op; logic [11:0] a; logic [3:0] s;
      op = int'($urandom % 10); a = rand_addr();
      s = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      if (op < 5) axw(a, $urandom, s, '0);
      else if (op < 8) rd_chk(a, tag_of(a));
      else if (op == 8) pulse(NC'($urandom));
      else axw(a, $urandom, s, NC'($urandom));
      check_outs();
    end
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 2 + 2 * NB; w++) begin
        logic [11:0] a;
        a = (w == 0) ? 12'(12'h20C + 12'h100 * c) : (w == 1) ? 12'(12'h220 + 12'h100 * c)
                     : 12'(12'h224 + 12'h100 * c + 4 * (w - 2));
        rd_chk(a, tag_of(a));
      end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule